// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block decides when the chip's clocks may run. Software requests a low-power state by writing a control word whose bit 0 is 1. The block then drops the oscillator enable and the PLL enable. The gated clock enable for the rest of the chip falls with them. The sequencer itself runs from an always-on clock.

While the chip is powered down, the block watches three wake sources: resume signalling on the host bus, a dedicated wakeup pin, and a second wakeup pin. The second pin can be handed over to general-purpose I/O, and in that mode it cannot wake the chip. All three inputs are synchronised first. Each is then compared against a programmable active level.

On a wake, the oscillator enable rises first. After a fixed oscillator start window the PLL enable rises. After a parameterised PLL lock window, which models the roughly 200 µs settle time, the clock enable rises. In that same cycle a one-cycle wakeup interrupt fires, and a sticky cause register records which sources were active. If a wake source is already active when power-down is requested, the clocks are never gated and the interrupt fires at once. Wake handling does not depend on whether the bus is attached.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset, `osc_en`, `pll_en` and `clk_en` are 1, `wake_irq` is 0 and `wake_cause` is 0.
- R2: A cycle with `pd_write`=1 and `pd_bit`=1 while running, with no wake source active, makes `osc_en`, `pll_en` and `clk_en` all 0 from the next cycle on.
- R3: A cycle with `pd_write`=1 and `pd_bit`=0 has no effect: the clocks stay enabled.
- R4: Each wake source ends power-down when it is at its active level. Source index 0 is `bus_resume`, 1 is `wake_pin` and 2 is `wake2_pin`. `wake_pol[i]`=1 means source i is active high, and 0 means active low.
- R5: While `wake2_gpio`=1, `wake2_pin` never ends power-down and never sets `wake_cause[2]`.
- R6: Counting clock edges from the first edge at which a wake level is present on the pin, `osc_en` rises after edge SYNC_STAGES+1. `pll_en` rises OSC_START_CYCLES edges later. `clk_en` rises PLL_LOCK_CYCLES edges after that. `pll_en` is never 1 while `osc_en` is 0.
- R7: `wake_irq` is high for exactly one cycle. On a wake from power-down it coincides with the rise of `clk_en`, and it is only ever high while `clk_en` is 1.
- R8: `wake_cause` bits are set, in the cycle `wake_irq` fires, for every source that was active when the wake was detected. They hold until a cycle with `cause_clr`=1. A set in the same cycle as a clear wins.
- R9: A power-down request that arrives while a wake source is already active leaves all enables at 1. It fires `wake_irq` in the next cycle and records that source in `wake_cause`.
- R10: `clk_en` is never 1 unless both `osc_en` and `pll_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_write | input | 1 | Strobe for a write to the power control word |
| pd_bit | input | 1 | Bit 0 of the written control word; 1 requests power-down |
| bus_resume | input | 1 | Resume signalling seen on the host bus (wake source 0) |
| wake_pin | input | 1 | Dedicated wakeup pin (wake source 1) |
| wake2_pin | input | 1 | Second wakeup pin, shared with general-purpose I/O (wake source 2) |
| wake_pol | input | 3 | Active level per wake source, 1 = high |
| wake2_gpio | input | 1 | 1 hands the second pin to general-purpose I/O |
| cause_clr | input | 1 | Clears the sticky wake cause bits |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_en | output | 1 | Clock release to the rest of the chip |
| wake_irq | output | 1 | One-cycle wakeup interrupt |
| wake_cause | output | 3 | Sticky record of the wake sources, same indices as R4 |

## Verification
The assertions check a set of invariants on every cycle. The enables are always ordered, so `clk_en` never runs ahead of the oscillator and PLL, and the PLL never runs without the oscillator. The interrupt is always a single pulse tied to running clocks. A rise of `clk_en` is always paired with the interrupt. Cause bits never drop without a clear, and a write with bit 0 clear never gates the clocks. Some behaviour needs known stimulus and can only be shown by the bench's scenarios: the exact edge counts of the wake sequence, the polarity decoding of each source, the masking of the second pin in general-purpose mode, the contents of the cause register and the immediate-return case.

// File: rtl/pwr_wake_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes: three wake sources, whose index order is also the bit order of the cause register.
package pwr_wake_pkg;

    localparam int N_WAKE_SRC = 3;
    localparam int SRC_RESUME = 0;
    localparam int SRC_PIN    = 1;
    localparam int SRC_PIN2   = 2;

    typedef enum logic [1:0] {
        PW_RUN       = 2'd0,
        PW_DOWN      = 2'd1,
        PW_OSC_START = 2'd2,
        PW_PLL_WAIT  = 2'd3
    } pw_state_e;

endpackage

// File: rtl/pwr_wake_sync.sv
// Module: pwr_wake_sync
// Synchronises each wake input through a flop chain and decodes it into an
// "active" level using a per-source polarity bit and a per-source mask.
// Assumes: STAGES >= 2; polarity and mask are quasi-static configuration.
module pwr_wake_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] mask,
    output logic [N-1:0] act
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [STAGES-1:0] shreg;

        // Shift the raw pin into the synchroniser; reset to the inactive level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= {STAGES{~pol[g]}};
            end else begin
                shreg <= {shreg[STAGES-2:0], raw[g]};
            end
        end

        assign act[g] = (shreg[STAGES-1] == pol[g]) && !mask[g];
    end

endmodule

// File: rtl/pwr_wake_timer.sv
// Module: pwr_wake_timer
// Loadable down-counter that times the oscillator start and PLL lock windows.
// Assumes: a load value of K makes done rise after K further clock edges.
module pwr_wake_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pwr_wake_fsm.sv
// Module: pwr_wake_fsm
// Four-state sequencer: running, powered down, oscillator start, PLL wait.
// Drives the timer, latches the sources seen at wake, and issues the
// interrupt pulse together with the cause bits to set.
// Assumes: the power-down write strobe is honoured only while running.
module pwr_wake_fsm
    import pwr_wake_pkg::*;
#(
    parameter int N           = 3,
    parameter int CW          = 8,
    parameter int OSC_CYCLES  = 8,
    parameter int LOCK_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_write,
    input  logic          pd_bit,
    input  logic [N-1:0]  act,
    input  logic          tmr_done,
    output pw_state_e     state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          irq,
    output logic [N-1:0]  cause_set
);

    localparam logic [CW-1:0] OSC_LOAD  = CW'(OSC_CYCLES - 1);
    localparam logic [CW-1:0] LOCK_LOAD = CW'(LOCK_CYCLES - 1);

    pw_state_e    state_q, state_d;
    logic [N-1:0] src_q, src_d;
    logic         irq_q, irq_d;
    logic         any_act;

    assign any_act = |act;

    // Next-state, timer load and interrupt decision.
    always_comb begin
        state_d   = state_q;
        src_d     = src_q;
        irq_d     = 1'b0;
        cause_set = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            PW_RUN: begin
                if (pd_write && pd_bit) begin
                    if (any_act) begin
                        irq_d     = 1'b1;
                        cause_set = act;
                    end else begin
                        state_d = PW_DOWN;
                    end
                end
            end
            PW_DOWN: begin
                if (any_act) begin
                    state_d  = PW_OSC_START;
                    src_d    = act;
                    tmr_load = 1'b1;
                    tmr_val  = OSC_LOAD;
                end
            end
            PW_OSC_START: begin
                if (tmr_done) begin
                    state_d  = PW_PLL_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LOCK_LOAD;
                end
            end
            PW_PLL_WAIT: begin
                if (tmr_done) begin
                    state_d   = PW_RUN;
                    irq_d     = 1'b1;
                    cause_set = src_q;
                end
            end
            default: state_d = PW_RUN;
        endcase
    end

    // State, latched wake sources and the interrupt pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PW_RUN;
            src_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            irq_q   <= irq_d;
        end
    end

    assign state = state_q;
    assign irq   = irq_q;

endmodule

// File: rtl/pwr_wake_cause.sv
// Module: pwr_wake_cause
// Sticky wake cause register: clear on request, set wins over clear.
// Assumes: set is driven in the same cycle that schedules the interrupt pulse.
module pwr_wake_cause #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] cause
);

    logic [N-1:0] cause_q;

    // Accumulate set bits; a clear drops only the bits not being set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~{N{clr}}) | set;
        end
    end

    assign cause = cause_q;

endmodule

// File: rtl/pwr_wake_seq.sv
// Module: pwr_wake_seq (top)
// Power-down and wakeup sequencer. Gates the oscillator and PLL enables on
// a software request and restores them in order on a wake from any of three
// sources, raising the interrupt only after the PLL lock window.
// Assumes: clk is always on; OSC_START_CYCLES >= 1, PLL_LOCK_CYCLES >= 1,
// SYNC_STAGES >= 2.
module pwr_wake_seq
    import pwr_wake_pkg::*;
#(
    parameter int OSC_START_CYCLES = 8,
    parameter int PLL_LOCK_CYCLES  = 9600,
    parameter int SYNC_STAGES      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_write,
    input  logic                  pd_bit,
    input  logic                  bus_resume,
    input  logic                  wake_pin,
    input  logic                  wake2_pin,
    input  logic [N_WAKE_SRC-1:0] wake_pol,
    input  logic                  wake2_gpio,
    input  logic                  cause_clr,
    output logic                  osc_en,
    output logic                  pll_en,
    output logic                  clk_en,
    output logic                  wake_irq,
    output logic [N_WAKE_SRC-1:0] wake_cause
);

    localparam int MAX_CYC = (OSC_START_CYCLES > PLL_LOCK_CYCLES) ?
                             OSC_START_CYCLES : PLL_LOCK_CYCLES;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [N_WAKE_SRC-1:0] raw_w, mask_w, act_w, set_w;
    logic                  tmr_load, tmr_done;
    logic [CW-1:0]         tmr_val;
    pw_state_e             state;

    // Gather the wake pins in source-index order and mask the shared pin.
    always_comb begin
        raw_w             = '0;
        mask_w            = '0;
        raw_w[SRC_RESUME] = bus_resume;
        raw_w[SRC_PIN]    = wake_pin;
        raw_w[SRC_PIN2]   = wake2_pin;
        mask_w[SRC_PIN2]  = wake2_gpio;
    end

    pwr_wake_sync #(
        .N      (N_WAKE_SRC),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_w),
        .pol   (wake_pol),
        .mask  (mask_w),
        .act   (act_w)
    );

    pwr_wake_timer #(
        .CW (CW)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pwr_wake_fsm #(
        .N           (N_WAKE_SRC),
        .CW          (CW),
        .OSC_CYCLES  (OSC_START_CYCLES),
        .LOCK_CYCLES (PLL_LOCK_CYCLES)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_write  (pd_write),
        .pd_bit    (pd_bit),
        .act       (act_w),
        .tmr_done  (tmr_done),
        .state     (state),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .irq       (wake_irq),
        .cause_set (set_w)
    );

    pwr_wake_cause #(
        .N (N_WAKE_SRC)
    ) cause_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_w),
        .clr   (cause_clr),
        .cause (wake_cause)
    );

    // Enable decode from the sequencer state.
    always_comb begin
        osc_en = (state != PW_DOWN);
        pll_en = (state == PW_RUN) || (state == PW_PLL_WAIT);
        clk_en = (state == PW_RUN);
    end

endmodule

// File: rtl/pwr_wake_seq_chk.sv
// Module: pwr_wake_seq_chk
// Cycle-by-cycle invariants on the sequencer ports, bound to pwr_wake_seq.
// Assumes: synchronous active-low reset on rst_n.
module pwr_wake_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_write,
    input logic       pd_bit,
    input logic       cause_clr,
    input logic       osc_en,
    input logic       pll_en,
    input logic       clk_en,
    input logic       wake_irq,
    input logic [2:0] wake_cause
);

    assert_clk_needs_plls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (osc_en && pll_en));

    assert_pll_needs_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> osc_en);

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    assert_irq_with_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> clk_en);

    assert_clk_rise_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> wake_irq);

    assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(wake_cause) & ~wake_cause)) |-> $past(cause_clr));

    assert_bit_clear_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_write && !pd_bit && clk_en) |=> clk_en);

endmodule

bind pwr_wake_seq pwr_wake_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_write   (pd_write),
    .pd_bit     (pd_bit),
    .cause_clr  (cause_clr),
    .osc_en     (osc_en),
    .pll_en     (pll_en),
    .clk_en     (clk_en),
    .wake_irq   (wake_irq),
    .wake_cause (wake_cause)
);

// File: tb/pwr_wake_seq_tb_top.sv
// Bench for pwr_wake_seq: directed corner cases plus seeded random wakes.
module pwr_wake_seq_tb_top;

    localparam int OSC  = 5;
    localparam int PLL  = 37;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_write = 1'b0, pd_bit = 1'b0, cause_clr = 1'b0;
    logic       bus_resume = 1'b0, wake_pin = 1'b0, wake2_pin = 1'b0;
    logic       wake2_gpio = 1'b0;
    logic [2:0] wake_pol = 3'b111;
    logic       osc_en, pll_en, clk_en, wake_irq;
    logic [2:0] wake_cause;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_wake_seq #(
        .OSC_START_CYCLES (OSC),
        .PLL_LOCK_CYCLES  (PLL),
        .SYNC_STAGES      (SYNC)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_write   (pd_write),
        .pd_bit     (pd_bit),
        .bus_resume (bus_resume),
        .wake_pin   (wake_pin),
        .wake2_pin  (wake2_pin),
        .wake_pol   (wake_pol),
        .wake2_gpio (wake2_gpio),
        .cause_clr  (cause_clr),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .clk_en     (clk_en),
        .wake_irq   (wake_irq),
        .wake_cause (wake_cause)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cause(input logic [2:0] m, input logic g);
        return g ? (m & 3'b011) : m;
    endfunction

    function automatic int exp_osc_edge();
        return SYNC + 1;
    endfunction

    function automatic int exp_pll_edge();
        return SYNC + 1 + OSC;
    endfunction

    function automatic int exp_irq_edge();
        return SYNC + 1 + OSC + PLL;
    endfunction

    task automatic set_levels(input logic [2:0] lvl);
        {wake2_pin, wake_pin, bus_resume} = lvl;
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // One full power-down and wake with sources m, pin mode g, polarity p.
    task automatic run_wake(input logic [2:0] m, input logic g,
                            input logic [2:0] p, input int gap);
        logic [2:0] eff;
        int n, c_osc, c_pll, c_irq;
        @(negedge clk);
        wake_pol = p; wake2_gpio = g; set_levels(~p);
        repeat (4) @(negedge clk);
        cause_clr = 1'b1;
        @(negedge clk);
        cause_clr = 1'b0;
        chk("R8", "cause after clear", wake_cause, 0);
        pd_write = 1'b1; pd_bit = 1'b1;
        @(negedge clk);
        pd_write = 1'b0; pd_bit = 1'b0;
        chk("R2", "osc_en gated", osc_en, 0);
        chk("R2", "pll_en gated", pll_en, 0);
        chk("R2", "clk_en gated", clk_en, 0);
        repeat (gap) @(negedge clk);
        eff = m;
        if (m == 3'b100 && g) begin
            set_levels(~p ^ 3'b100);
            repeat (60) @(negedge clk);
            chk("R5", "osc_en stays off with pin as gpio", osc_en, 0);
            chk("R5", "clk_en stays off with pin as gpio", clk_en, 0);
            eff = 3'b101;
        end
        set_levels(~p ^ eff);
        n = 0; c_osc = -1; c_pll = -1; c_irq = -1;
        while (c_irq < 0 && n < 400) begin
            @(negedge clk);
            n++;
            if (osc_en && c_osc < 0) c_osc = n;
            if (pll_en && c_pll < 0) c_pll = n;
            if (wake_irq) c_irq = n;
        end
        chk("R6", "osc_en rise edge", c_osc, exp_osc_edge());
        chk("R6", "pll_en rise edge", c_pll, exp_pll_edge());
        chk("R7", "irq edge", c_irq, exp_irq_edge());
        chk("R7", "clk_en with irq", clk_en, 1);
        chk("R4", "cause sources", wake_cause, exp_cause(eff, g));
        @(negedge clk);
        chk("R7", "irq one cycle", wake_irq, 0);
        set_levels(~p);
        repeat (5) @(negedge clk);
        chk("R8", "cause held", wake_cause, exp_cause(eff, g));
        chk("R10", "clocks run after wake", {osc_en, pll_en, clk_en}, 3'b111);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset osc_en", osc_en, 1);
        chk("R1", "reset pll_en", pll_en, 1);
        chk("R1", "reset clk_en", clk_en, 1);
        chk("R1", "reset irq", wake_irq, 0);
        chk("R1", "reset cause", wake_cause, 0);

        // R3: write with bit 0 clear
        pd_write = 1'b1; pd_bit = 1'b0;
        @(negedge clk);
        pd_write = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3", "clk_en after bit0=0 write", clk_en, 1);
        chk("R3", "osc_en after bit0=0 write", osc_en, 1);

        // Directed wakes covering every source and polarity
        run_wake(3'b001, 1'b0, 3'b111, 0);
        run_wake(3'b010, 1'b0, 3'b000, 3);
        run_wake(3'b100, 1'b0, 3'b101, 2);
        run_wake(3'b100, 1'b1, 3'b111, 1);
        run_wake(3'b110, 1'b1, 3'b010, 0);

        // R9: wake already active at request; clear and set in one cycle
        @(negedge clk);
        wake_pol = 3'b111; wake2_gpio = 1'b0; set_levels(3'b001);
        repeat (4) @(negedge clk);
        pd_write = 1'b1; pd_bit = 1'b1; cause_clr = 1'b1;
        @(negedge clk);
        pd_write = 1'b0; pd_bit = 1'b0; cause_clr = 1'b0;
        chk("R9", "clk_en kept", clk_en, 1);
        chk("R9", "osc_en kept", osc_en, 1);
        chk("R9", "irq at once", wake_irq, 1);
        chk("R8", "set wins over clear", wake_cause, 3'b001);
        @(negedge clk);
        chk("R9", "irq single", wake_irq, 0);
        chk("R9", "clk_en still on", clk_en, 1);
        set_levels(3'b000);

        // Seeded random wakes
        for (int i = 0; i < 20; i++) begin
            logic [2:0] m, p;
            logic g;
            m = 3'($urandom_range(1, 7));
            p = 3'($urandom_range(0, 7));
            g = 1'($urandom_range(0, 1));
            run_wake(m, g, p, int'($urandom_range(0, 10)));
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule